// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the device-side status logic of a parallel NOR flash. It watches the host's write strobes for the unlock-and-command sequences. It then runs one of three internal jobs: a word program, an erase of the whole array, or an erase of a chosen set of sectors. Each job lasts a parameterised number of clock cycles. While a job runs, every host read returns a status byte in place of array data. Bit 6 of that byte inverts on every read. Bit 5 reports a time-limit failure. Bit 3 tells the host whether the erase has begun, or whether the window for adding more sectors is still open.

A small register array stands in for the flash cells so that completed jobs can be seen through reads. A job that cannot finish, such as programming a word that is not blank, runs into the time limit. The block then locks up and keeps reporting status. Only the synchronous reset brings it back to normal reads, and that reset also returns the stub array to all-ones.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `busy` is 0, every word of the stub array reads 0xFF, and `rd_data` shows the result of a read on the clock edge that samples `rd_stb`.
- R2: The program job launches on the four writes (0x15,0xAA), (0x0A,0x55), (0x15,0xA0), (addr,data). `busy` is 1 from the edge that samples the fourth strobe. After PROG_CYC further edges the word holds `data` and `busy` drops.
- R3: The whole-array erase launches on the six writes (0x15,0xAA), (0x0A,0x55), (0x15,0x80), (0x15,0xAA), (0x0A,0x55), (0x15,0x10). It keeps `busy` high for ERASE_CYC edges and then leaves every word at 0xFF.
- R4: While a job is active or locked, each read returns a status byte. Bit 6 is 0 on the first read after launch and inverts on every later read. Bit 5 is the time-limit flag, bit 3 is the erase-in-progress flag, and bits 7, 4, 2, 1 and 0 are 0.
- R5: Once a job completes, reads return array contents again.
- R6: A sector-erase sequence is the R3 sequence with last write (addr,0x30). The sector is addr[5:4]. It opens a window of WIN_CYC edges in which bit 3 reads 0. Inside the window, a single write of 0x30 to any address adds that address's sector and restarts the window. After the window closes, bit 3 reads 1 for ERASE_CYC edges. Then exactly the chosen sectors read 0xFF.
- R7: While the erase itself runs (bit 3 = 1), every write is ignored. That includes 0x30 writes and complete command sequences, so words outside the chosen sectors keep their values.
- R8: A program to a word that does not read 0xFF never completes. LIMIT_CYC edges after launch, bit 5 reads 1 and `busy` is 0. Bit 6 keeps inverting on every read, writes are ignored, and every read returns status.
- R9: Reset leaves the locked state, and later command sequences work normally.
- R10: A write that breaks a sequence returns decoding to its start. Nothing launches, and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe (the host's write edge) |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result: array word or status byte |
| busy | output | 1 | High while a job is in its window or running |

## Verification
`busy` changes on the same edge that samples the final command strobe. `rd_data` changes on the edge that samples `rd_stb`. Completion falls PROG_CYC or ERASE_CYC edges after launch. A sector erase adds WIN_CYC edges after the last accepted 0x30 write. The lockout falls LIMIT_CYC edges after a non-blank program launch. The bench drives every input on falling edges and advances a queue-based model on each rising edge. It compares `rd_data` and `busy` with the model at every falling edge, half a cycle after the edge on which the result becomes due. The directed reads are timed so that status reads land inside each job's run. Writes meant to be ignored land inside the erase run, before its last edge.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    // Status layout fixes the bus at one byte
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] ERASED = '1;

    localparam logic [DATA_W-1:0] CODE_UNLOCK1 = 8'hAA;
    localparam logic [DATA_W-1:0] CODE_UNLOCK2 = 8'h55;
    localparam logic [DATA_W-1:0] CODE_PROG    = 8'hA0;
    localparam logic [DATA_W-1:0] CODE_ERASE   = 8'h80;
    localparam logic [DATA_W-1:0] CODE_CHIP    = 8'h10;
    localparam logic [DATA_W-1:0] CODE_SECTOR  = 8'h30;

    typedef enum logic [1:0] {PH_ARRAY, PH_WINDOW, PH_RUN, PH_LOCKED} phase_e;
    typedef enum logic [1:0] {JOB_NONE, JOB_PROG, JOB_CHIP, JOB_SECTOR} job_e;
    typedef enum logic [2:0] {SQ_IDLE, SQ_U1, SQ_U2, SQ_PADDR, SQ_E1, SQ_E2, SQ_E3} seq_e;

    typedef struct packed {
        logic toggle;
        logic timed_out;
        logic erasing;
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_status(stat_t s);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[6] = s.toggle;
        w[5] = s.timed_out;
        w[3] = s.erasing;
        return w;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsg_cmd_decode.sv
module fsg_cmd_decode import fsg_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter logic [ADDR_W-1:0] UNL_A1 = 6'h15,
    parameter logic [ADDR_W-1:0] UNL_A2 = 6'h0A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              launch,
    output job_e              launch_job
);

    seq_e seq_q, seq_d;
    logic at_a1, at_a2;

    assign at_a1 = (wr_addr == UNL_A1);
    assign at_a2 = (wr_addr == UNL_A2);

    always_comb begin
        seq_d      = seq_q;
        launch     = 1'b0;
        launch_job = JOB_NONE;
        if (accept && wr_stb) begin
            seq_d = SQ_IDLE;
            unique case (seq_q)
                SQ_IDLE:  if (at_a1 && wr_data == CODE_UNLOCK1) seq_d = SQ_U1;
                SQ_U1:    if (at_a2 && wr_data == CODE_UNLOCK2) seq_d = SQ_U2;
                SQ_U2: begin
                    if (at_a1 && wr_data == CODE_PROG)       seq_d = SQ_PADDR;
                    else if (at_a1 && wr_data == CODE_ERASE) seq_d = SQ_E1;
                end
                SQ_PADDR: begin
                    launch     = 1'b1;
                    launch_job = JOB_PROG;
                end
                SQ_E1:    if (at_a1 && wr_data == CODE_UNLOCK1) seq_d = SQ_E2;
                SQ_E2:    if (at_a2 && wr_data == CODE_UNLOCK2) seq_d = SQ_E3;
                SQ_E3: begin
                    if (at_a1 && wr_data == CODE_CHIP) begin
                        launch     = 1'b1;
                        launch_job = JOB_CHIP;
                    end else if (wr_data == CODE_SECTOR) begin
                        launch     = 1'b1;
                        launch_job = JOB_SECTOR;
                    end
                end
                default: seq_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !accept) seq_q <= SQ_IDLE;
        else                seq_q <= seq_d;
    end

endmodule

// File: rtl/fsg_engine.sv
module fsg_engine import fsg_pkg::*; #(
    parameter int ADDR_W    = 6,
    parameter int SECT_W    = 4,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20,
    parameter int WIN_CYC   = 10,
    parameter int LIMIT_CYC = 40,
    localparam int IDX_W    = ADDR_W - SECT_W,
    localparam int NSECT    = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  job_e              launch_job,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [DATA_W-1:0] launch_data,
    input  logic [DATA_W-1:0] peek_data,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  wr_sect,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output phase_e            phase,
    output logic              busy,
    output logic [DATA_W-1:0] status,
    output logic              pgm_we,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              erase_en,
    output logic [NSECT-1:0]  erase_mask
);

    localparam int SPAN  = imax(imax(PROG_CYC, ERASE_CYC), imax(WIN_CYC, LIMIT_CYC));
    localparam int CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] LIMIT_LAST = CNT_W'(LIMIT_CYC - 1);

    job_e             job_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tog_q, stuck_q;
    logic [NSECT-1:0] sect_q, launch_bit, wr_bit;
    logic             run_last, run_done, win_extra;
    stat_t            st_word;

    assign launch_bit = NSECT'(1) << launch_addr[ADDR_W-1:SECT_W];
    assign wr_bit     = NSECT'(1) << wr_sect;

    always_comb begin
        run_last  = (job_q == JOB_PROG) ? (cnt_q == PROG_LAST) : (cnt_q == ERASE_LAST);
        run_done  = (phase == PH_RUN) && !stuck_q && run_last;
        win_extra = (phase == PH_WINDOW) && wr_stb && (wr_data == CODE_SECTOR);
        busy      = (phase == PH_WINDOW) || (phase == PH_RUN);
        pgm_we    = run_done && (job_q == JOB_PROG);
        erase_en  = run_done && (job_q != JOB_PROG);
        erase_mask = (job_q == JOB_CHIP) ? '1 : sect_q;
        st_word.toggle    = tog_q;
        st_word.timed_out = (phase == PH_LOCKED);
        st_word.erasing   = ((phase == PH_RUN) || (phase == PH_LOCKED)) && (job_q != JOB_PROG);
        status = pack_status(st_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_ARRAY;
            job_q    <= JOB_NONE;
            cnt_q    <= '0;
            tog_q    <= 1'b0;
            stuck_q  <= 1'b0;
            sect_q   <= '0;
            pgm_addr <= '0;
            pgm_data <= '0;
        end else begin
            if (launch && phase == PH_ARRAY)    tog_q <= 1'b0;
            else if (rd_stb && phase != PH_ARRAY) tog_q <= ~tog_q;

            case (phase)
                PH_ARRAY: if (launch) begin
                    job_q    <= launch_job;
                    cnt_q    <= '0;
                    pgm_addr <= launch_addr;
                    pgm_data <= launch_data;
                    stuck_q  <= (launch_job == JOB_PROG) && (peek_data != ERASED);
                    sect_q   <= launch_bit;
                    phase    <= (launch_job == JOB_SECTOR) ? PH_WINDOW : PH_RUN;
                end
                PH_WINDOW: begin
                    if (win_extra) begin
                        sect_q <= sect_q | wr_bit;
                        cnt_q  <= '0;
                    end else if (cnt_q == WIN_LAST) begin
                        phase <= PH_RUN;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (stuck_q && cnt_q == LIMIT_LAST) phase <= PH_LOCKED;
                    else if (run_done)                   phase <= PH_ARRAY;
                    else                                 cnt_q <= cnt_q + 1'b1;
                end
                PH_LOCKED: phase <= PH_LOCKED;
                default:   phase <= PH_ARRAY;
            endcase
        end
    end

    // Busy follows the final command strobe on the next edge
    assert_busy_after_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        (launch && phase == PH_ARRAY) |=> busy);

    // Decoder never launches while a job owns the engine
    assert_no_launch_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_ARRAY) |-> !launch);

    // Extra-sector window reports bit 3 low
    assert_window_bit3_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WINDOW) |-> !status[3]);

    // Lockout is permanent until reset and flags bit 5
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOCKED) |=> (phase == PH_LOCKED) && status[5] && !busy);

    // Run counter never passes the time limit
    assert_run_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN) |-> (cnt_q <= LIMIT_LAST));

endmodule

// File: rtl/fsg_array.sv
module fsg_array import fsg_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int NSECT = 1 << (ADDR_W - SECT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_we,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              erase_en,
    input  logic [NSECT-1:0]  erase_mask,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              show_status,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  wipe;

    for (genvar w = 0; w < DEPTH; w++) begin : g_wipe
        assign wipe[w] = erase_en & erase_mask[w >> SECT_W];
    end

    assign peek_data = mem[peek_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
            rd_data <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wipe[i])                                  mem[i] <= ERASED;
                else if (pgm_we && pgm_addr == ADDR_W'(i))    mem[i] <= pgm_data;
            end
            if (rd_stb) rd_data <= show_status ? status : mem[rd_addr];
        end
    end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen import fsg_pkg::*; #(
    parameter int ADDR_W    = 6,
    parameter int SECT_W    = 4,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20,
    parameter int WIN_CYC   = 10,
    parameter int LIMIT_CYC = 40,
    parameter logic [ADDR_W-1:0] UNL_A1 = 6'h15,
    parameter logic [ADDR_W-1:0] UNL_A2 = 6'h0A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);

    localparam int IDX_W = ADDR_W - SECT_W;
    localparam int NSECT = 1 << IDX_W;

    phase_e            phase;
    logic              launch;
    job_e              launch_job;
    logic [DATA_W-1:0] peek_data, status, pgm_data;
    logic              pgm_we, erase_en;
    logic [ADDR_W-1:0] pgm_addr;
    logic [NSECT-1:0]  erase_mask;

    fsg_cmd_decode #(.ADDR_W(ADDR_W), .UNL_A1(UNL_A1), .UNL_A2(UNL_A2)) u_decode (
        .clk(clk), .rst(rst), .accept(phase == PH_ARRAY),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .launch(launch), .launch_job(launch_job)
    );

    fsg_engine #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC), .LIMIT_CYC(LIMIT_CYC)
    ) u_engine (
        .clk(clk), .rst(rst), .launch(launch), .launch_job(launch_job),
        .launch_addr(wr_addr), .launch_data(wr_data), .peek_data(peek_data),
        .wr_stb(wr_stb), .wr_sect(wr_addr[ADDR_W-1:SECT_W]), .wr_data(wr_data),
        .rd_stb(rd_stb), .phase(phase), .busy(busy), .status(status),
        .pgm_we(pgm_we), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .erase_en(erase_en), .erase_mask(erase_mask)
    );

    fsg_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst(rst), .pgm_we(pgm_we), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .erase_en(erase_en), .erase_mask(erase_mask),
        .peek_addr(wr_addr), .peek_data(peek_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .show_status(phase != PH_ARRAY),
        .status(status), .rd_data(rd_data)
    );

endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;

    localparam int AW = 6, SW = 4, PC = 8, EC = 20, WC = 10, LC = 40;
    localparam int A1 = 'h15, A2 = 'h0A;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0, rst = 1'b1, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy;

    always #4 clk = ~clk;

    flash_status_gen #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC),
                       .WIN_CYC(WC), .LIMIT_CYC(LC)) i_flash_status_gen (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    int checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mem [64];
    int m_phase, m_tmr, m_job, m_tog, m_stuck, m_pa, m_pd, exp_rd;
    bit m_sect [4];
    int wlog [$];

    function automatic int pk(int a, int d);
        return (a << 8) | d;
    endfunction

    // 0 broken, 1 partial, 2 program, 3 whole erase, 4 sector erase
    function automatic int classify();
        int n = wlog.size();
        if (wlog[0] != pk(A1, 'hAA)) return 0;
        if (n == 1) return 1;
        if (wlog[1] != pk(A2, 'h55)) return 0;
        if (n == 2) return 1;
        if (wlog[2] == pk(A1, 'hA0)) return (n == 3) ? 1 : 2;
        if (wlog[2] != pk(A1, 'h80)) return 0;
        if (n == 3) return 1;
        if (wlog[3] != pk(A1, 'hAA)) return 0;
        if (n == 4) return 1;
        if (wlog[4] != pk(A2, 'h55)) return 0;
        if (n == 5) return 1;
        if (wlog[5] == pk(A1, 'h10)) return 3;
        if ((wlog[5] & 255) == 'h30) return 4;
        return 0;
    endfunction

    function automatic int m_status();
        int erase_on = ((m_phase == 2 || m_phase == 3) && m_job != 1) ? 1 : 0;
        return (m_tog << 6) | ((m_phase == 3 ? 1 : 0) << 5) | (erase_on << 3);
    endfunction

    always @(posedge clk) begin
        int cls, last;
        cyc++;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 255;
            m_phase = 0; m_tog = 0; exp_rd = 0; m_job = 0;
            wlog.delete();
        end else begin
            if (rd_stb) begin
                if (m_phase != 0) begin exp_rd = m_status(); m_tog ^= 1; end
                else exp_rd = m_mem[rd_addr];
            end
            case (m_phase)
                0: if (wr_stb) begin
                    wlog.push_back(pk(int'(wr_addr), int'(wr_data)));
                    cls = classify();
                    if (cls != 1) begin
                        last = wlog[wlog.size()-1];
                        if (cls == 2) begin
                            m_job = 1; m_pa = last >> 8; m_pd = last & 255;
                            m_stuck = (m_mem[m_pa] != 255) ? 1 : 0;
                            m_phase = 2; m_tmr = m_stuck ? LC : PC;
                        end else if (cls == 3) begin
                            m_job = 2; m_phase = 2; m_tmr = EC;
                        end else if (cls == 4) begin
                            m_job = 3; m_phase = 1; m_tmr = WC;
                            foreach (m_sect[s]) m_sect[s] = 0;
                            m_sect[(last >> 8) >> SW] = 1;
                        end
                        if (cls >= 2) m_tog = 0;
                        wlog.delete();
                    end
                end
                1: if (wr_stb && wr_data == 8'h30) begin
                    m_sect[wr_addr >> SW] = 1; m_tmr = WC;
                end else begin
                    m_tmr--;
                    if (m_tmr == 0) begin m_phase = 2; m_tmr = EC; end
                end
                2: begin
                    m_tmr--;
                    if (m_tmr == 0) begin
                        if (m_job == 1 && m_stuck) m_phase = 3;
                        else begin
                            if (m_job == 1) m_mem[m_pa] = m_pd;
                            else foreach (m_mem[i])
                                if (m_job == 2 || m_sect[i >> SW]) m_mem[i] = 255;
                            m_phase = 0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // per-clock comparison, half a cycle after each rising edge
    always @(negedge clk) begin
        if (!rst) begin
            check({cur_req, " model rd_data"}, int'(rd_data), exp_rd);
            check({cur_req, " model busy"}, int'(busy), (m_phase == 1 || m_phase == 2) ? 1 : 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk); wr_stb = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk); rd_stb = 1'b1; rd_addr = AW'(a);
        @(negedge clk); rd_stb = 1'b0;
        check(req, int'(rd_data), exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_word(input int a, input int d);
        wr(A1, 'hAA); wr(A2, 'h55); wr(A1, 'hA0); wr(a, d);
    endtask

    task automatic erase_prefix();
        wr(A1, 'hAA); wr(A2, 'h55); wr(A1, 'h80); wr(A1, 'hAA); wr(A2, 'h55);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc >= WATCHDOG) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;

        // R1: reset state
        cur_req = "R1";
        check("R1 busy after reset", int'(busy), 0);
        rd(0, 'hFF, "R1 word 0 erased");
        rd(63, 'hFF, "R1 word 63 erased");

        // R2, R4, R5: program with toggling status
        cur_req = "R2";
        program_word(3, 'h5A);
        check("R2 busy after 4th strobe", int'(busy), 1);
        cur_req = "R4";
        rd(3, 'h00, "R4 first status read bit6=0");
        rd(3, 'h40, "R4 second status read bit6=1");
        rd(3, 'h00, "R4 third status read bit6=0");
        idle(PC);
        cur_req = "R5";
        check("R5 busy low after program", int'(busy), 0);
        rd(3, 'h5A, "R5 programmed word");

        program_word(20, 'hC3); idle(PC + 2);
        program_word(40, 'h77); idle(PC + 2);
        rd(20, 'hC3, "R2 word 20");

        // R10: broken sequence
        cur_req = "R10";
        wr(A1, 'hAA); wr(A2, 'h55); wr(A1, 'h77); wr(3, 'h11);
        check("R10 no launch", int'(busy), 0);
        rd(3, 'h5A, "R10 word 3 untouched");

        // R6, R7: sector erase with an added sector
        cur_req = "R6";
        erase_prefix(); wr(3, 'h30);
        rd(0, 'h00, "R6 window status bit3=0");
        wr(20, 'h30);
        rd(0, 'h40, "R6 window after add bit3=0");
        idle(WC + 2);
        rd(0, 'h08, "R6 erase running bit3=1");
        cur_req = "R7";
        wr(40, 'h30);
        program_word(41, 'h00);
        idle(EC + 5);
        check("R7 busy low after sector erase", int'(busy), 0);
        rd(3, 'hFF, "R6 sector 0 erased");
        rd(20, 'hFF, "R6 added sector 1 erased");
        rd(40, 'h77, "R7 sector 2 kept");
        rd(41, 'hFF, "R7 program during erase ignored");

        // R3: whole-array erase
        cur_req = "R3";
        erase_prefix(); wr(A1, 'h10);
        check("R3 busy after 6th strobe", int'(busy), 1);
        rd(0, 'h08, "R3 status bit3=1");
        rd(0, 'h48, "R3 status toggled");
        idle(EC);
        rd(40, 'hFF, "R3 word 40 erased");

        // R8: non-blank program locks out
        cur_req = "R8";
        program_word(5, 'h12); idle(PC + 2);
        program_word(5, 'h34);
        idle(LC + 3);
        check("R8 busy low in lockout", int'(busy), 0);
        rd(5, 'h20, "R8 lock status bit5");
        rd(5, 'h60, "R8 lock status still toggling");
        program_word(6, 'h00);
        rd(6, 'h20, "R8 writes ignored, status returned");

        // R9: reset clears lockout
        cur_req = "R9";
        rst = 1'b1; idle(2); rst = 1'b0;
        check("R9 busy after reset", int'(busy), 0);
        rd(5, 'hFF, "R9 array reads after reset");
        program_word(7, 'h3C); idle(PC + 2);
        rd(7, 'h3C, "R9 program after reset");

        finish_run();
    end

endmodule